// File: doc/BRIEF.md
# Single-Cell Overvoltage Fault Delay Controller

This block is the digital core of a secondary protector for one lithium-ion cell. Each clock it receives a millivolt code for the cell and a millivolt code for the supply rail. When the cell code rises strictly above a fixed build-time threshold, the block starts counting one-millisecond ticks. It raises a fuse-trigger output only if the cell stays above the threshold for the whole qualifying delay. If the cell falls back before the delay ends, the count is dropped and the output stays low.

Once the trigger is high, it stays high until the cell code drops strictly below a release level, which is the threshold minus a hysteresis band. The normal delay is a build-time choice of 4000 or 6500 ticks. While the supply code exceeds the cell code by at least 10000 mV, a test mode shortens the delay to 15 ticks. The test mode ends as soon as that difference shrinks. A pending output shows when a qualification is in progress.

Top module: `ovp_delay_guard`

## Requirements
- R1: While the trigger is low, a cell code strictly greater than THRESH_MV (default 4350) sets `pending` on the next clock. A code equal to the threshold does not set it.
- R2: With the cell held above the threshold, `fuse_drive` rises on the clock that samples the 4000th asserted `tick_1ms`, which is the default short option. It does not rise earlier, and clocks without a tick do not advance the count.
- R3: A cell code at or below the threshold before the delay expires clears `pending` on the next clock and leaves `fuse_drive` low. A later excursion then needs a full delay again.
- R4: While `fuse_drive` is high, it stays high for any cell code at or above THRESH_MV - HYST_MV (default 4050).
- R5: While `fuse_drive` is high, a cell code strictly below THRESH_MV - HYST_MV drives it low on the next clock.
- R6: `in_test` is high exactly when supply_mv >= cell_mv + 10000. In that mode the delay is 15 ticks.
- R7: `in_test` falls as soon as supply_mv < cell_mv + 10000, and the normal delay applies again.
- R8: When `in_test` changes while a qualification is running, the tick count restarts from zero against the newly selected delay. A tick in the cycle of the change is not counted.
- R9: A synchronous reset leaves `fuse_drive` and `pending` low and clears the count.
- R10: `pending` and `fuse_drive` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_mv | input | 16 | Cell voltage code in millivolts |
| supply_mv | input | 16 | Supply voltage code in millivolts |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| fuse_drive | output | 1 | Fuse trigger; high in overvoltage mode |
| in_test | output | 1 | Shortened-delay test mode active |
| pending | output | 1 | Delay qualification in progress |

## Verification
A stale or miscounted tick counter shows up as `fuse_drive` rising one tick early or late. The bench therefore samples the edge on exactly the Nth tick, both after a cancelled excursion and after a mode switch. A wrong comparison bound shows up within one clock as `pending` or `fuse_drive` responding to a code that sits exactly on the threshold or on the release level. A missed restart on a mode change lets a count carried over from the long delay trip the short delay too soon. This is visible within 15 ticks of the switch.

// File: rtl/ovp_delay_guard.sv
module ovp_delay_guard #(
  parameter int MV_W             = 16,
  parameter int THRESH_MV        = 4350,
  parameter int HYST_MV          = 300,
  parameter int LONG_DELAY       = 0,
  parameter int SHORT_OPT_TICKS  = 4000,
  parameter int LONG_OPT_TICKS   = 6500,
  parameter int TEST_TICKS       = 15,
  parameter int TEST_DIFF_MV     = 10000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MV_W-1:0] cell_mv,
  input  logic [MV_W-1:0] supply_mv,
  input  logic            tick_1ms,
  output logic            fuse_drive,
  output logic            in_test,
  output logic            pending
);
  localparam int NORM_TICKS = (LONG_DELAY != 0) ? LONG_OPT_TICKS : SHORT_OPT_TICKS;
  localparam int MAX_TICKS  = (NORM_TICKS > TEST_TICKS) ? NORM_TICKS : TEST_TICKS;
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);
  localparam int RELEASE_MV = THRESH_MV - HYST_MV;

  logic             tripped, pend_q, test_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             above, below_rel;

  assign above     = cell_mv > MV_W'(THRESH_MV);
  assign below_rel = cell_mv < MV_W'(RELEASE_MV);
  assign in_test   = {1'b0, supply_mv} >= ({1'b0, cell_mv} + (MV_W+1)'(TEST_DIFF_MV));
  assign lim       = in_test ? CNT_W'(TEST_TICKS - 1) : CNT_W'(NORM_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tripped <= 1'b0;
      pend_q  <= 1'b0;
      test_q  <= 1'b0;
      cnt     <= '0;
    end else begin
      test_q <= in_test;
      if (tripped) begin
        pend_q <= 1'b0;
        cnt    <= '0;
        if (below_rel) tripped <= 1'b0;
      end else if (!above) begin
        pend_q <= 1'b0;
        cnt    <= '0;
      end else if (in_test != test_q) begin
        pend_q <= 1'b1;
        cnt    <= '0;
      end else if (tick_1ms && cnt >= lim) begin
        tripped <= 1'b1;
        pend_q  <= 1'b0;
        cnt     <= '0;
      end else begin
        pend_q <= 1'b1;
        if (tick_1ms) cnt <= cnt + 1'b1;
      end
    end
  end

  assign fuse_drive = tripped;
  assign pending    = pend_q;

  p_trip_needs_above_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fuse_drive) |-> $past(cell_mv > MV_W'(THRESH_MV)) && $past(tick_1ms));

  p_count_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    (in_test == test_q && !tripped) |-> cnt <= lim);

  p_cancel_r3: assert property (@(posedge clk) disable iff (rst)
    (!fuse_drive && cell_mv <= MV_W'(THRESH_MV)) |=> !fuse_drive && !pending);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (fuse_drive && cell_mv >= MV_W'(RELEASE_MV)) |=> fuse_drive);

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (fuse_drive && cell_mv < MV_W'(RELEASE_MV)) |=> !fuse_drive);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(fuse_drive && pending));
endmodule

// File: tb/test_ovp_delay_guard.sv
module test_ovp_delay_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cell_mv, supply_mv;
  logic        tick_1ms;
  logic        fuse_drive, in_test, pending;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  ovp_delay_guard i_ovp_delay_guard (
    .clk(clk), .rst(rst), .cell_mv(cell_mv), .supply_mv(supply_mv),
    .tick_1ms(tick_1ms), .fuse_drive(fuse_drive), .in_test(in_test), .pending(pending)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; cell_mv = 16'd4400; supply_mv = 16'd5000; tick_1ms = 1'b1;
    step(3);
    chk("R9 fuse low in reset", fuse_drive, 0);
    chk("R9 pending low in reset", pending, 0);
    cell_mv = 16'd3700; tick_1ms = 1'b0; rst = 1'b0;
    step(1);
    chk("R9 fuse low after reset", fuse_drive, 0);
  endtask

  task automatic t_normal_trip;
    cell_mv = 16'd4350; supply_mv = 16'd5000; tick_1ms = 1'b1;
    step(2);
    chk("R1 equal code no pending", pending, 0);
    tick_1ms = 1'b0; cell_mv = 16'd4351;
    step(1);
    chk("R1 pending set", pending, 1);
    step(50);
    chk("R2 no advance without tick", fuse_drive, 0);
    tick_1ms = 1'b1;
    step(3999);
    chk("R2 not before last tick", fuse_drive, 0);
    chk("R10 pending while qualifying", pending, 1);
    step(1);
    chk("R2 trip on 4000th tick", fuse_drive, 1);
    chk("R10 pending cleared on trip", pending, 0);
    tick_1ms = 1'b0; cell_mv = 16'd4050;
    step(5);
    chk("R4 hold at release level", fuse_drive, 1);
    cell_mv = 16'd4049;
    step(1);
    chk("R5 release below level", fuse_drive, 0);
  endtask

  task automatic t_cancel;
    cell_mv = 16'd4400; supply_mv = 16'd5000; tick_1ms = 1'b1;
    step(3000);
    cell_mv = 16'd4350;
    step(1);
    chk("R3 pending cleared", pending, 0);
    chk("R3 fuse stays low", fuse_drive, 0);
    cell_mv = 16'd4400;
    step(3999);
    chk("R3 full delay needed again", fuse_drive, 0);
    step(1);
    chk("R3 trip after full delay", fuse_drive, 1);
    tick_1ms = 1'b0; cell_mv = 16'd3000;
    step(1);
    chk("R5 release", fuse_drive, 0);
  endtask

  task automatic t_test_mode;
    cell_mv = 16'd4400; supply_mv = 16'd14399; tick_1ms = 1'b0;
    step(1);
    chk("R7 diff below 10V not test", in_test, 0);
    supply_mv = 16'd14400;
    step(1);
    chk("R6 test at exact diff", in_test, 1);
    tick_1ms = 1'b1;
    step(14);
    chk("R6 not before 15th tick", fuse_drive, 0);
    step(1);
    chk("R6 trip on 15th tick", fuse_drive, 1);
    tick_1ms = 1'b0; cell_mv = 16'd3000; supply_mv = 16'd3000;
    step(1);
    chk("R7 test ends", in_test, 0);
    chk("R5 release after test", fuse_drive, 0);
  endtask

  task automatic t_mode_switch;
    cell_mv = 16'd4400; supply_mv = 16'd14400; tick_1ms = 1'b1;
    step(10);
    supply_mv = 16'd14399;
    step(1);
    chk("R7 test drops mid count", in_test, 0);
    step(3999);
    chk("R8 restart against long delay", fuse_drive, 0);
    step(1);
    chk("R8 trip after full normal delay", fuse_drive, 1);
    tick_1ms = 1'b0; cell_mv = 16'd3000; supply_mv = 16'd5000;
    step(1);
    cell_mv = 16'd4400; tick_1ms = 1'b1;
    step(100);
    supply_mv = 16'd14400;
    step(1);
    chk("R8 switch into test", in_test, 1);
    step(14);
    chk("R8 carried count discarded", fuse_drive, 0);
    step(1);
    chk("R8 trip on 15th test tick", fuse_drive, 1);
    tick_1ms = 1'b0; cell_mv = 16'd3000; supply_mv = 16'd5000;
    step(1);
  endtask

  initial begin
    step(1);
    t_reset();
    t_normal_trip();
    t_cancel();
    t_test_mode();
    t_mode_switch();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule